// File: doc/BRIEF.md
# Fractional microsecond tick generator

This block turns an oscillator of arbitrary frequency into a one-microsecond time base. A 16-bit ratio setting states how many input clocks make one microsecond as a fraction: the low byte holds the clock count minus one (the dividend field) and the high byte holds the microsecond count minus one (the divisor field). The block therefore averages (divisor+1) tick pulses for every (dividend+1) input clocks. An error accumulator spreads those pulses as evenly as the ratio allows. For example, 0x000B suits a 12 MHz source and 0x045F suits 19.2 MHz, where 96 clocks yield 5 microseconds.

Every tick advances a free-running 32-bit up-counter, and the counter wraps on overflow. A small register bus gives access to the counter, the ratio setting and a freeze control. Freeze stops the accumulator and the counter together. The ratio may be rewritten at any time, for example after a power-state change, and the new value applies from the next clock.

Top module: `fmt_tick`

## Requirements
- R1: After reset the counter is 0, `tick` is 0, the ratio setting is 0x000B and freeze is clear.
- R2: On each clock with freeze clear and no ratio write, the accumulator grows by (divisor+1). When the sum reaches (dividend+1) or more, (dividend+1) is taken off and `tick` is high for the following cycle. Otherwise `tick` is low.
- R3: With the ratio fixed and freeze clear, any (dividend+1) consecutive clocks produce exactly (divisor+1) ticks. For example, 0x045F gives 5 ticks per 96 clocks and 0x04BF gives 5 ticks per 192 clocks.
- R4: The counter rises by exactly 1 in the cycle `tick` is high and otherwise holds. It wraps from 0xFFFFFFFF to 0.
- R5: While freeze (bit 0 of the freeze register) is set, `tick` stays low and neither the counter nor the accumulator changes. A write to freeze takes effect from the next clock.
- R6: A write to the ratio register takes effect from the next clock. It clears the accumulator, and no tick results from that clock even if one was due.
- R7: When the divisor field is greater than or equal to the dividend field, a tick occurs on every clock that is not frozen and not a ratio write.
- R8: Reads are combinational. Address 0x00 returns the counter, 0x04 returns the ratio in bits 15:0, 0x08 returns freeze in bit 0, and any other address returns 0.
- R9: A write to address 0x00 loads the counter with the written value, and this overrides any increment in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| tick | output | 1 | One-cycle microsecond pulse |
| usec_count | output | 32 | Microsecond counter value |

## Verification
Two functions can fall in the same cycle: a ratio write, and a tick that the accumulator would otherwise produce. The bench provokes this case directly. It uses its behavioural model to find a cycle in which the accumulator is about to overflow, and it writes the ratio exactly then. The check expects `tick` to stay low and the counter to hold in that cycle. The bench also loads the counter in a cycle where a tick is due, and it checks that the loaded value wins over the increment.

// File: rtl/fmt_tick.sv
module fmt_tick #(
  parameter logic [7:0]  ADR_CNT = 8'h00,
  parameter logic [7:0]  ADR_CFG = 8'h04,
  parameter logic [7:0]  ADR_FRZ = 8'h08,
  parameter logic [15:0] CFG_RST = 16'h000B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        tick,
  output logic [31:0] usec_count
);
  logic [15:0] cfg_q;
  logic        frz_q;
  logic [8:0]  acc_q;
  logic [8:0]  acc_d;

  wire [8:0] num = {1'b0, cfg_q[15:8]} + 9'd1;
  wire [8:0] den = {1'b0, cfg_q[7:0]} + 9'd1;
  wire [9:0] sum = {1'b0, acc_q} + {1'b0, num};
  wire [9:0] rem = sum - {1'b0, den};
  wire       cfg_wr = wr_en && (addr == ADR_CFG);
  wire       cnt_wr = wr_en && (addr == ADR_CNT);
  wire       frz_wr = wr_en && (addr == ADR_FRZ);
  wire       hit = !frz_q && !cfg_wr && (sum >= {1'b0, den});

  always_comb begin
    if (frz_q)                    acc_d = acc_q;
    else if (!hit)                acc_d = sum[8:0];
    else if (rem >= {1'b0, den})  acc_d = '0;
    else                          acc_d = rem[8:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_RST;
      frz_q      <= 1'b0;
      acc_q      <= '0;
      tick       <= 1'b0;
      usec_count <= '0;
    end else begin
      tick <= hit;
      if (cfg_wr) begin
        cfg_q <= wr_data[15:0];
        acc_q <= '0;
      end else begin
        acc_q <= acc_d;
      end
      if (frz_wr) frz_q <= wr_data[0];
      if (cnt_wr)   usec_count <= wr_data;
      else if (hit) usec_count <= usec_count + 32'd1;
    end
  end

  always_comb begin
    case (addr)
      ADR_CNT: rd_data = usec_count;
      ADR_CFG: rd_data = {16'd0, cfg_q};
      ADR_FRZ: rd_data = {31'd0, frz_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fmt_tick_chk.sv
module fmt_tick_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic        tick,
  input logic [31:0] cnt,
  input logic [15:0] cfg,
  input logic        frz
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cnt == 32'd0 && !tick && cfg == 16'h000B && !frz));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 8'h00) |=> (cnt == $past(cnt) + {31'd0, tick}));

  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !wr_en) |=> ($stable(cnt) && !tick));

  a_r6_cfg_write_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h04) |=> !tick);

  a_r7_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[15:8] >= cfg[7:0] && !frz && !wr_en) |=> tick);
endmodule

bind fmt_tick fmt_tick_chk u_fmt_tick_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .tick(tick), .cnt(usec_count), .cfg(cfg_q), .frz(frz_q)
);

// File: tb/test_fmt_tick.sv
module test_fmt_tick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick;
  logic [31:0] usec_count;

  int checks = 0;
  int errors = 0;

  int          m_acc = 0;
  int          m_tick = 0;
  logic [31:0] m_cnt = '0;
  logic [15:0] m_cfg = 16'h000B;
  logic        m_frz = 1'b0;
  int          tick_sum = 0;

  fmt_tick i_fmt_tick (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .usec_count(usec_count)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_cnt;
      8'h04:   return {16'd0, m_cfg};
      8'h08:   return {31'd0, m_frz};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int m_due();
    return (!m_frz && (m_acc + int'(m_cfg[15:8]) + 1 >= int'(m_cfg[7:0]) + 1)) ? 1 : 0;
  endfunction

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d);
    int num, den, s;
    wr_en = we; addr = a; wr_data = d;
    @(posedge clk);
    num = int'(m_cfg[15:8]) + 1;
    den = int'(m_cfg[7:0]) + 1;
    if (we && a == 8'h04) begin
      m_cfg = d[15:0]; m_acc = 0; m_tick = 0;
    end else begin
      m_tick = 0;
      if (!m_frz) begin
        s = m_acc + num;
        if (s >= den) begin
          m_tick = 1; s = s - den;
          if (s >= den) s = 0;
        end
        m_acc = s;
        if (m_tick == 1) m_cnt = m_cnt + 32'd1;
      end
      if (we && a == 8'h00) m_cnt = d;
      if (we && a == 8'h08) m_frz = d[0];
    end
    tick_sum += m_tick;
    @(negedge clk);
    chk(tick == (m_tick == 1), "R2 tick", {31'd0, tick}, m_tick);
    chk(usec_count == m_cnt, "R4 counter", usec_count, m_cnt);
    chk(rd_data == m_read(addr), "R8 read", rd_data, m_read(addr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, '0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tick == 1'b0 && usec_count == 0, "R1 reset outputs", usec_count, 0);
    rst_n = 1'b1;
    addr = 8'h04;
    #1;
    chk(rd_data == 32'h0000_000B, "R1 reset ratio", rd_data, 32'h0000_000B);
    addr = 8'h08;
    #1;
    chk(rd_data == 32'h0, "R1 reset freeze", rd_data, 32'h0);
    idle(40);

    cyc(1'b1, 8'h04, 32'h0000_045F);
    tick_sum = 0; idle(96);
    chk(tick_sum == 5, "R3 0x045F ticks per 96", tick_sum, 5);
    tick_sum = 0; idle(96);
    chk(tick_sum == 5, "R3 0x045F second window", tick_sum, 5);
    cyc(1'b1, 8'h04, 32'h0000_04BF);
    tick_sum = 0; idle(192);
    chk(tick_sum == 5, "R3 0x04BF ticks per 192", tick_sum, 5);
    cyc(1'b1, 8'h04, 32'h0000_0453);
    tick_sum = 0; idle(84);
    chk(tick_sum == 5, "R3 0x0453 ticks per 84", tick_sum, 5);

    cyc(1'b1, 8'h08, 32'h1);
    tick_sum = 0; idle(30);
    chk(tick_sum == 0, "R5 no ticks while frozen", tick_sum, 0);
    cyc(1'b1, 8'h08, 32'h0);
    idle(30);

    for (int k = 0; k < 3; k++) begin
      while (m_due() == 0) idle(1);
      cyc(1'b1, 8'h04, 32'h0000_043F);
      chk(tick == 1'b0, "R6 ratio write suppresses due tick", {31'd0, tick}, 0);
      idle(17 + k);
    end

    while (m_due() == 0) idle(1);
    cyc(1'b1, 8'h00, 32'h1234_0000);
    chk(usec_count == 32'h1234_0000, "R9 load beats increment", usec_count, 32'h1234_0000);

    cyc(1'b1, 8'h04, 32'h0000_0505);
    tick_sum = 0; idle(20);
    chk(tick_sum == 20, "R7 equal fields tick every cycle", tick_sum, 20);
    cyc(1'b1, 8'h04, 32'h0000_0A03);
    tick_sum = 0; idle(20);
    chk(tick_sum == 20, "R7 divisor above dividend", tick_sum, 20);

    cyc(1'b1, 8'h04, 32'h0000_0000);
    cyc(1'b1, 8'h00, 32'hFFFF_FFFE);
    idle(3);
    chk(usec_count == 32'h0000_0001, "R4 wrap", usec_count, 32'h1);

    cyc(1'b0, 8'h0C, '0);
    chk(rd_data == 32'h0, "R8 unmapped address", rd_data, 32'h0);
    cyc(1'b1, 8'h04, 32'h0000_000C);
    idle(60);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule